// File: doc/BRIEF.md
# Windowed Two-Bank Byte Memory

This block is a 512-byte read/write store that sits on a processor-style bus with a 10-bit byte address and an 8-bit data bus shared by both directions. Inside it are two 256-byte synchronous banks. A decoder uses the top address bit to decide whether an access falls in the block's window. It uses the next bit down to choose one of the two banks. The lower eight bits pick a byte within that bank.

By default the window covers `$200`–`$3FF`: addresses with bit 8 set go to one bank (`$300`–`$3FF`) and addresses with bit 8 clear go to the other (`$200`–`$2FF`). Setting the `WIN_HIGH` parameter to 0 moves the window to `$000`–`$1FF`. Outside the window the block neither stores anything nor drives the bus. Other devices can therefore share the same bus in the remaining half of the address space.

A write is taken at a rising clock edge while chip select is high and the read/write line is low. During a write the data bus is an input. A read is requested with chip select, read/write and output enable all high. The byte appears on the bus in the cycle after the edge that sampled the request, and stays there while the request is held. Bank contents are undefined after reset.

Top module: `dual_bank_sram`

## Requirements
- R1: With `cs_i`=1, `rd_wr_n_i`=0 and an in-window address, the byte on `data_io` is stored at the addressed location on the rising edge. The block does not drive `data_io` while `rd_wr_n_i` is 0.
- R2: A read request has `cs_i`=1, `rd_wr_n_i`=1, `oe_i`=1 and an in-window address. When the rising edge samples one, the last byte written to that address appears on `data_io` in the following cycle, for as long as `cs_i`, `rd_wr_n_i` and `oe_i` stay high.
- R3: Address bit 8 selects the bank (1 selects the bank at `$x00`+`$100`). Addresses that differ only in bit 8 hold independent bytes, and one access writes at most one bank.
- R4: A write whose address bit 9 differs from `WIN_HIGH` changes no stored byte.
- R5: A read request whose address bit 9 differs from `WIN_HIGH` leaves `data_io` undriven in the following cycle.
- R6: With `cs_i`=0 nothing is stored and `data_io` is left undriven.
- R7: With `oe_i`=0 a read request leaves `data_io` undriven.
- R8: In the cycle after reset has been sampled high, `data_io` is undriven even if a read request is presented.
- R9: With `WIN_HIGH`=0 the window is `$000`–`$1FF`, with the same bank selection by bit 8 and the same read and write behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all storage and the read pipeline update on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset of the read pipeline |
| addr_i | input | 10 | Byte address: bit 9 window, bit 8 bank, bits 7:0 byte offset |
| cs_i | input | 1 | Chip select, active high |
| rd_wr_n_i | input | 1 | 1 requests a read, 0 requests a write |
| oe_i | input | 1 | Output enable, active high |
| data_io | inout | 8 | Bidirectional data bus; driven only for an accepted read |

## Verification
The hardest case to reach is a write just outside the window whose address matches an in-window location in every bit except bit 9. A decoder that ignores bit 9 would alias the two, and would then corrupt the in-window byte with no visible sign. The bench runs a default-window instance and a low-window instance side by side on the same address and control lines. Every write therefore lands in one window and misses the other. Each instance is read back against its own model. Directed cases pair `$2AB`/`$0AB`/`$3AB` to target bank and window aliasing, and random traffic then mixes hits, misses, deselects and disabled outputs. An undriven bus reads as all ones through a pulled-up net, and the written data never uses that value.

// File: rtl/dual_bank_sram_pkg.sv
`timescale 1ns/1ps
package dual_bank_sram_pkg;
    localparam int ADDR_W    = 10;
    localparam int DATA_W    = 8;
    localparam int NUM_BANKS = 2;
    localparam int BANK_AW   = ADDR_W - 2;
    localparam int WIN_BIT   = ADDR_W - 1;
    localparam int BANK_BIT  = ADDR_W - 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } mem_op_e;

    typedef struct packed {
        mem_op_e              op;
        logic                 bank;
        logic [BANK_AW-1:0]   offs;
    } mem_req_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a, input logic high);
        return a[WIN_BIT] == high;
    endfunction
endpackage

// File: rtl/dual_bank_sram_decode.sv
`timescale 1ns/1ps
module dual_bank_sram_decode
    import dual_bank_sram_pkg::*;
#(
    parameter bit WIN_HIGH = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs_i,
    input  logic              rd_wr_n_i,
    input  logic              oe_i,
    output mem_req_t          req_o
);
    logic hit;

    always_comb begin
        hit        = cs_i && in_window(addr_i, WIN_HIGH);
        req_o.bank = addr_i[BANK_BIT];
        req_o.offs = addr_i[BANK_AW-1:0];
        if (!hit)
            req_o.op = OP_IDLE;
        else if (!rd_wr_n_i)
            req_o.op = OP_WRITE;
        else if (oe_i)
            req_o.op = OP_READ;
        else
            req_o.op = OP_IDLE;
    end
endmodule

// File: rtl/dual_bank_sram_bank.sv
`timescale 1ns/1ps
module dual_bank_sram_bank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic          re_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i)
            store[addr_i] <= wdata_i;
        if (re_i)
            rdata_o <= store[addr_i];
    end
endmodule

// File: rtl/dual_bank_sram.sv
`timescale 1ns/1ps
module dual_bank_sram
    import dual_bank_sram_pkg::*;
#(
    parameter bit WIN_HIGH = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs_i,
    input  logic              rd_wr_n_i,
    input  logic              oe_i,
    inout  wire  [DATA_W-1:0] data_io
);
    mem_req_t             req;
    logic [NUM_BANKS-1:0] bank_we;
    logic [NUM_BANKS-1:0] bank_re;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];
    logic                 rd_pend_q;
    logic                 rd_bank_q;
    logic                 drv_en;
    logic [DATA_W-1:0]    rd_byte;

    dual_bank_sram_decode #(.WIN_HIGH(WIN_HIGH)) u_decode (
        .addr_i    (addr_i),
        .cs_i      (cs_i),
        .rd_wr_n_i (rd_wr_n_i),
        .oe_i      (oe_i),
        .req_o     (req)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_we[b] = (req.op == OP_WRITE) && (req.bank == b[0]);
        assign bank_re[b] = (req.op == OP_READ)  && (req.bank == b[0]);

        dual_bank_sram_bank #(.AW(BANK_AW), .DW(DATA_W)) u_bank (
            .clk_i   (clk_i),
            .we_i    (bank_we[b]),
            .re_i    (bank_re[b]),
            .addr_i  (req.offs),
            .wdata_i (data_io),
            .rdata_o (bank_rdata[b])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_pend_q <= 1'b0;
            rd_bank_q <= 1'b0;
        end else begin
            rd_pend_q <= (req.op == OP_READ);
            if (req.op == OP_READ)
                rd_bank_q <= req.bank;
        end
    end

    assign rd_byte = bank_rdata[rd_bank_q];
    assign drv_en  = rd_pend_q && cs_i && rd_wr_n_i && oe_i;
    assign data_io = drv_en ? rd_byte : {DATA_W{1'bz}};
endmodule

// File: rtl/dual_bank_sram_checker.sv
`timescale 1ns/1ps
module dual_bank_sram_checker
    import dual_bank_sram_pkg::*;
#(
    parameter bit WIN_HIGH = 1'b1
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic                 cs_i,
    input logic                 rd_wr_n_i,
    input logic                 oe_i,
    input logic [NUM_BANKS-1:0] bank_we,
    input logic                 drv_en
);
    logic win;
    assign win = (addr_i[ADDR_W-1] == WIN_HIGH);

    AST_QUIET_ON_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        (cs_i && !rd_wr_n_i) |-> !drv_en);                         // R1
    AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (rst_i)
        (cs_i && rd_wr_n_i && oe_i && win) |=> (drv_en == (cs_i && rd_wr_n_i && oe_i))); // R2
    AST_ONE_BANK_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(bank_we));                                         // R3
    AST_NO_WRITE_OUTSIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        !win |-> (bank_we == '0));                                  // R4
    AST_MISS_UNDRIVEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (cs_i && rd_wr_n_i && !win) |=> !drv_en);                   // R5
    AST_DESELECT_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !cs_i |-> (!drv_en && bank_we == '0));                      // R6
    AST_OE_LOW_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !oe_i |-> !drv_en);                                         // R7
    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> !drv_en);                                         // R8
endmodule

bind dual_bank_sram dual_bank_sram_checker #(.WIN_HIGH(WIN_HIGH)) u_checker (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .addr_i    (addr_i),
    .cs_i      (cs_i),
    .rd_wr_n_i (rd_wr_n_i),
    .oe_i      (oe_i),
    .bank_we   (bank_we),
    .drv_en    (drv_en)
);

// File: tb/tb_dual_bank_sram.sv
`timescale 1ns/1ps
module tb_dual_bank_sram;
    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] addr;
    logic       cs, rw, oe;
    logic       drv;
    logic [7:0] wd;
    tri1  [7:0] bus_hi;
    tri1  [7:0] bus_lo;

    assign bus_hi = drv ? wd : 8'hzz;
    assign bus_lo = drv ? wd : 8'hzz;

    always #2.5 clk = ~clk;

    dual_bank_sram #(.WIN_HIGH(1'b1)) dut (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .cs_i(cs),
        .rd_wr_n_i(rw), .oe_i(oe), .data_io(bus_hi)
    );
    dual_bank_sram #(.WIN_HIGH(1'b0)) dut_lo (
        .clk_i(clk), .rst_i(rst), .addr_i(addr), .cs_i(cs),
        .rd_wr_n_i(rw), .oe_i(oe), .data_io(bus_lo)
    );

    logic [7:0] m_hi [1024];
    bit         v_hi [1024];
    logic [7:0] m_lo [1024];
    bit         v_lo [1024];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic bit hit(input logic [9:0] a, input bit high);
        return a[9] == high;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h (addr %03h)", req, act, exp, addr);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Apply at a falling edge, pass one rising edge, return at the next falling edge.
    task automatic access(input logic [9:0] a, input bit c, input bit r, input bit o,
                          input logic [7:0] d);
        addr = a; cs = c; rw = r; oe = o; wd = d; drv = !r;
        @(posedge clk);
        if (c && !r) begin
            if (hit(a, 1'b1)) begin m_hi[a] = d; v_hi[a] = 1; end
            if (hit(a, 1'b0)) begin m_lo[a] = d; v_lo[a] = 1; end
        end
        @(negedge clk);
        if (r) begin
            // undriven bus reads 8'hFF; written data never equals FF
            if (!c) begin
                check("R6", bus_hi, 8'hFF); check("R6", bus_lo, 8'hFF);
            end else if (!o) begin
                check("R7", bus_hi, 8'hFF); check("R7", bus_lo, 8'hFF);
            end else begin
                if (!hit(a, 1'b1))  check("R5", bus_hi, 8'hFF);
                else if (v_hi[a])   check("R2", bus_hi, m_hi[a]);
                if (!hit(a, 1'b0))  check("R9", bus_lo, 8'hFF);
                else if (v_lo[a])   check("R9", bus_lo, m_lo[a]);
            end
        end
    endtask

    initial begin
        fork
            begin
                #2_000_000;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
                finish_run();
            end
        join_none

        void'($urandom(32'd4242));
        rst = 1; addr = 10'h2AB; cs = 1; rw = 1; oe = 1; drv = 0; wd = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R8: read request present while reset was sampled; bus must be quiet now
        check("R8", bus_hi, 8'hFF);
        check("R8", bus_lo, 8'hFF);

        // R1/R2: write then read back
        access(10'h2AB, 1, 0, 1, 8'h42);
        access(10'h2AB, 1, 1, 1, 8'h00);
        check("R1", bus_hi, 8'h42);
        // R3: other bank, same offset
        access(10'h3AB, 1, 0, 1, 8'h5A);
        access(10'h2AB, 1, 1, 1, 8'h00);
        check("R3", bus_hi, 8'h42);
        access(10'h3AB, 1, 1, 1, 8'h00);
        check("R3", bus_hi, 8'h5A);
        // R4: out-of-window write aliasing in all but bit 9
        access(10'h0AB, 1, 0, 1, 8'h11);
        access(10'h2AB, 1, 1, 1, 8'h00);
        check("R4", bus_hi, 8'h42);
        // R9: low-window instance took that write
        access(10'h0AB, 1, 1, 1, 8'h00);
        check("R9", bus_lo, 8'h11);
        // R6: deselected write stores nothing
        access(10'h2AB, 0, 0, 1, 8'h77);
        m_hi[10'h2AB] = 8'h42;
        access(10'h2AB, 1, 1, 1, 8'h00);
        check("R6", bus_hi, 8'h42);
        // R7: output enable low
        access(10'h3AB, 1, 1, 0, 8'h00);

        for (int i = 0; i < 3000; i++) begin
            logic [9:0] a;
            a = 10'($urandom);
            if (i % 4 == 0) a = {a[9:8], 3'b000, a[4:0]};
            access(a, ($urandom % 8) != 0, $urandom % 2, ($urandom % 6) != 0,
                   8'($urandom % 255));
        end

        finish_run();
    end
endmodule